// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave side of a two-wire serial memory that only reads. A system clock oversamples the serial clock (`scl_in`) and the serial data line (`sda_in`). From these samples the block finds START and STOP conditions and takes in bytes most significant bit first. When it acknowledges a byte or sends a zero data bit, it pulls the open-drain data line low through `sda_drive_low`.

A single address counter selects the byte that is read from an internal byte array. The array holds `DEPTH` bytes, and `DEPTH` must be a power of two. A master loads the counter with a write-direction transaction that carries a two-byte word address. The master then does one of two things:

- It issues a repeated START and a read-direction address byte. This is a random read.
- It issues STOP. This sets the current address without reading.

A read-direction transaction that is not preceded by a new address continues from the counter's current value. Each byte the master acknowledges advances the counter, and the counter wraps from the last byte back to zero. After a STOP the block ignores the bus until it sees the next START.

Top module: `twire_rd_slave`

## Requirements
- R1: After reset, `sda_drive_low` is 0 and the block waits for START. The counter is 0.
- R2: The block acknowledges an address byte only when its upper four bits are 1010 and the next three bits equal the `SEL` parameter. Acknowledging means holding `sda_drive_low` at 1 through the ninth clock. The last bit gives the direction, and 1 means read. A byte that does not match gets no acknowledge, and all following bytes are ignored until the next START.
- R3: A random read has this sequence:
  - a write-direction address byte
  - word address high byte, then low byte, all acknowledged
  - a repeated START and a read-direction address byte

  The block then returns the byte at the loaded address. Array byte `a` holds (29·a + 7) mod 256.
- R4: Data bits go out most significant bit first. A 0 bit is driven low and a 1 bit is released. When the master acknowledges a data byte (data line low on the ninth clock), the counter advances by one, and the next byte comes from the new address.
- R5: After the byte at address `DEPTH`-1 is acknowledged, the counter wraps to 0 and reading continues.
- R6: A data byte that the master does not acknowledge ends the read and does not advance the counter. A later current-address read therefore returns the same byte.
- R7: A STOP after the acknowledged word address low byte keeps the new address. No data is output. The next current-address read returns the byte at that address.
- R8: After STOP, the block acknowledges nothing and drives nothing until a new START is seen.
- R9: Word address bits at and above bit log2(`DEPTH`) are ignored. The counter is loaded with the word address modulo `DEPTH`.
- R10: `sda_drive_low` changes only while SCL is low.
- R11: Bytes that follow the word address low byte in a write-direction transaction are not acknowledged, and they leave the loaded counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock from the master |
| sda_in | input | 1 | Resolved serial data line |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest situations to reach from the ports are the counter wrap inside one long sequential read, and the end of a read with no acknowledge. In both, the counter must have advanced on every acknowledged byte and on none of the others.

The stimulus first does a random read that puts the counter two bytes below the top of the array. It then acknowledges across the boundary and ends with no acknowledge. A following current-address read shows the counter's final value at the ports.

Standby after STOP, address mismatch and trailing write bytes are checked the same way. Each is followed by a current-address read, which shows that the counter was not disturbed.

// File: rtl/twire_rd_slave.sv
module twire_rd_slave #(
  parameter int DEPTH = 16,
  parameter logic [2:0] SEL = 3'b000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_drive_low
);
  localparam int AW = $clog2(DEPTH);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WA1, S_WA0, S_READ} st_t;

  logic [2:0] scl_r, sda_r;
  logic scl_q, scl_d, sda_q, sda_d;
  logic start_c, stop_c, rise, fall;
  st_t st;
  logic [3:0] bitc;
  logic [7:0] sh, hi, tx;
  logic [AW-1:0] cnt;
  logic rd, ack_drv, tx_en;
  logic [7:0] mem [DEPTH];

  assign scl_q = scl_r[1];
  assign scl_d = scl_r[2];
  assign sda_q = sda_r[1];
  assign sda_d = sda_r[2];
  assign start_c = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_c  = scl_q & scl_d & ~sda_d & sda_q;
  assign rise = scl_q & ~scl_d;
  assign fall = ~scl_q & scl_d;
  assign sda_drive_low = ack_drv | (tx_en & ~tx[7]);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_in};
      sda_r <= {sda_r[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      bitc <= 4'd0;
      sh <= 8'd0;
      hi <= 8'd0;
      tx <= 8'd0;
      cnt <= '0;
      rd <= 1'b0;
      ack_drv <= 1'b0;
      tx_en <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'((i * 29 + 7) % 256);
    end else if (start_c) begin
      st <= S_DEV;
      bitc <= 4'd0;
      ack_drv <= 1'b0;
      tx_en <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
      bitc <= 4'd0;
      ack_drv <= 1'b0;
      tx_en <= 1'b0;
    end else if (rise) begin
      if (st == S_READ) begin
        if (bitc < 4'd8) bitc <= bitc + 4'd1;
        else if (bitc == 4'd8) begin
          if (!sda_q) begin
            cnt <= cnt + 1'b1;
            bitc <= 4'd9;
          end else st <= S_IDLE;
        end
      end else if (st != S_IDLE) begin
        if (bitc < 4'd8) begin
          sh <= {sh[6:0], sda_q};
          bitc <= bitc + 4'd1;
        end else if (bitc == 4'd8 && ack_drv) bitc <= 4'd9;
      end
    end else if (fall) begin
      if (st == S_READ) begin
        if (bitc < 4'd8) tx <= {tx[6:0], 1'b0};
        else if (bitc == 4'd8) tx_en <= 1'b0;
        else begin
          tx <= mem[cnt];
          tx_en <= 1'b1;
          bitc <= 4'd0;
        end
      end else if (st != S_IDLE) begin
        if (bitc == 4'd8 && !ack_drv) begin
          case (st)
            S_DEV:
              if (sh[7:1] == {4'b1010, SEL}) begin
                ack_drv <= 1'b1;
                rd <= sh[0];
              end else st <= S_IDLE;
            S_WA1: begin
              ack_drv <= 1'b1;
              hi <= sh;
            end
            S_WA0: begin
              ack_drv <= 1'b1;
              cnt <= AW'({hi, sh});
            end
            default: st <= S_IDLE;
          endcase
        end else if (bitc == 4'd9) begin
          ack_drv <= 1'b0;
          bitc <= 4'd0;
          case (st)
            S_DEV:
              if (rd) begin
                st <= S_READ;
                tx <= mem[cnt];
                tx_en <= 1'b1;
              end else st <= S_WA1;
            S_WA1: st <= S_WA0;
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/twire_rd_slave_chk.sv
module twire_rd_slave_chk #(
  parameter int AW = 4
) (
  input logic clk,
  input logic rst,
  input logic scl_q,
  input logic start_c,
  input logic stop_c,
  input logic sda_drive_low,
  input logic [2:0] st,
  input logic [AW-1:0] cnt
);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    start_c |=> (st == 3'd1));

  p_inc_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == 3'd4 && cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));

  p_stop_r8: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> (st == 3'd0 && !sda_drive_low));

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd0) |-> !sda_drive_low);

  p_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_drive_low));
endmodule

bind twire_rd_slave twire_rd_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_q(scl_q), .start_c(start_c), .stop_c(stop_c),
  .sda_drive_low(sda_drive_low), .st(st), .cnt(cnt)
);

// File: tb/test_twire_rd_slave.sv
module test_twire_rd_slave;
  localparam int DEPTH = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic drv;
  logic sda_in;
  int total = 0, bad = 0, cnt_m = 0, viol = 0, cyc = 0;
  logic scl_p = 1'b1, drv_p = 1'b0;

  assign sda_in = sda_m & ~drv;
  always #10 clk = ~clk;

  twire_rd_slave #(.DEPTH(DEPTH), .SEL(3'b000)) i_twire_rd_slave (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_in), .sda_drive_low(drv));

  function automatic logic [7:0] byte_at(int a);
    return 8'((a * 29 + 7) % 256);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic h(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input bit b, output bit d);
    sda_m = b; h(5);
    scl = 1'b1; h(5);
    d = drv; h(5);
    scl = 1'b0; h(5);
  endtask

  task automatic start_c();
    sda_m = 1'b1; h(5);
    scl = 1'b1; h(5);
    sda_m = 1'b0; h(5);
    scl = 1'b0; h(5);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; h(5);
    scl = 1'b1; h(5);
    sda_m = 1'b1; h(10);
  endtask

  task automatic wbyte(input logic [7:0] b, input bit exp_ack, input string req);
    bit d;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], d);
    clk_bit(1'b1, d);
    chk(d == exp_ack, req, d, exp_ack);
  endtask

  task automatic rbyte(input logic [7:0] exp, input bit ack, input string req);
    bit d;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, d);
      got[i] = ~d;
    end
    chk(got == exp, req, got, exp);
    clk_bit(!ack, d);
    if (ack) cnt_m = (cnt_m + 1) % DEPTH;
  endtask

  task automatic load(input logic [7:0] a1, input logic [7:0] a0, input string req);
    start_c();
    wbyte(8'hA0, 1'b1, "R2");
    wbyte(a1, 1'b1, req);
    wbyte(a0, 1'b1, req);
    cnt_m = int'({a1, a0}) % DEPTH;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && scl && scl_p && drv != drv_p) viol++;
    scl_p = scl;
    drv_p = drv;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    h(5); rst = 1'b0; h(5);
    chk(drv == 1'b0, "R1", drv, 0);
    start_c(); wbyte(8'hA1, 1'b1, "R2");
    rbyte(byte_at(0), 1'b0, "R1"); stop_c();

    load(8'h00, 8'h05, "R3");
    start_c(); wbyte(8'hA1, 1'b1, "R2");
    rbyte(byte_at(cnt_m), 1'b0, "R3"); stop_c();

    start_c(); wbyte(8'hA1, 1'b1, "R2");
    rbyte(byte_at(cnt_m), 1'b0, "R6"); stop_c();

    load(8'h00, 8'h0E, "R3");
    start_c(); wbyte(8'hA1, 1'b1, "R2");
    rbyte(byte_at(cnt_m), 1'b1, "R4");
    rbyte(byte_at(cnt_m), 1'b1, "R5");
    rbyte(byte_at(cnt_m), 1'b1, "R5");
    rbyte(byte_at(cnt_m), 1'b0, "R4");
    stop_c();
    start_c(); wbyte(8'hA1, 1'b1, "R2");
    rbyte(byte_at(cnt_m), 1'b0, "R6"); stop_c();

    load(8'h00, 8'h09, "R7"); stop_c();
    start_c(); wbyte(8'hA1, 1'b1, "R2");
    rbyte(byte_at(cnt_m), 1'b0, "R7"); stop_c();

    load(8'hAB, 8'h73, "R9");
    start_c(); wbyte(8'hA1, 1'b1, "R2");
    rbyte(byte_at(3), 1'b1, "R9");
    rbyte(byte_at(cnt_m), 1'b0, "R9"); stop_c();

    start_c();
    wbyte(8'hA2, 1'b0, "R2");
    wbyte(8'hA1, 1'b0, "R2");
    stop_c();
    start_c(); wbyte(8'h91, 1'b0, "R2"); stop_c();
    start_c(); wbyte(8'hA1, 1'b1, "R2");
    rbyte(byte_at(cnt_m), 1'b0, "R2"); stop_c();

    scl = 1'b0; h(5);
    wbyte(8'hA1, 1'b0, "R8");
    wbyte(8'hA0, 1'b0, "R8");
    start_c(); wbyte(8'hA1, 1'b1, "R8");
    rbyte(byte_at(cnt_m), 1'b0, "R8"); stop_c();

    load(8'h00, 8'h02, "R11");
    wbyte(8'h55, 1'b0, "R11");
    stop_c();
    start_c(); wbyte(8'hA1, 1'b1, "R2");
    rbyte(byte_at(2), 1'b0, "R11"); stop_c();

    chk(viol == 0, "R10", viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule